// File: doc/BRIEF.md
# Serial Register Front End for a Display Controller

This block is the serial slave that a host processor uses to configure a small display controller. The host selects the device with an active-low chip select. It shifts bytes in on MOSI with the clock idling low, and the slave samples each bit on the rising clock edge, most significant bit first. Every framed transfer opens with a header byte. The header carries a fixed five-bit signature, a device-identity bit, a target bit and a direction bit. The target bit chooses between the 16-bit index pointer and the word that the pointer currently selects. The direction bit chooses between a write and a read.

Behind the serial logic sit three things: the index pointer, a bank of 16-bit configuration words, and a fixed device code at index zero. A status word can be read as well. Pixel memory is not stored here. While the index points at the pixel port, each incoming data word is handed out on a one-cycle strobe with its data. All serial pins are sampled by the fast system clock after a short synchronizer, so the serial clock must run well below the system clock.

Top module: `lcdc_spi_front`

## Requirements
- R1: A header byte is accepted only when bits 7..3 equal 01110 and bit 2 equals the DEV_ID parameter. Otherwise the rest of the frame changes no state, produces no strobe, and keeps spi_miso low until chip select rises.
- R2: A header with bit 1 (target) = 0 and bit 0 (direction) = 0 sets the 16-bit index to {byte 1, byte 2} once byte 2 completes. Later bytes in that frame are ignored.
- R3: A header with target = 1 and direction = 0 writes {byte 1, byte 2} to the word at the index. Every further complete byte pair writes again. A pair cut short by chip select rising writes nothing.
- R4: A header with target = 1 and direction = 1 returns 0x00 in byte 1, then the high and low bytes of the selected word in bytes 2 and 3, then 0x00 in any later byte. spi_miso changes after falling clock edges, most significant bit first.
- R5: Index 0x0000 reads as {0x922, DEV_REV}. Writing 0x0001 there sets osc_en, which stays set until reset. Any other value written there has no effect.
- R6: While the index is 0x0022, each data word is not stored. Instead gram_we pulses for one clock with gram_wdata equal to the word. A read at index 0x0022 returns 0x0000.
- R7: Words at indices REG_BASE to REG_BASE+NUM_REGS-1 (0x0001 to 0x0020 by default) reset to 0x0000 and are writable. Every other index, including any with a nonzero upper byte, reads 0x0000 and ignores writes.
- R8: A header with target = 0 and direction = 1 returns 0x00 in byte 1 and the status word {osc_en, 7'b0, index[7:0]} in bytes 2 and 3.
- R9: Raising chip select clears the bit and byte position, so the next frame starts cleanly even after a partial byte. spi_miso is low while the device is deselected.
- R10: After reset, spi_miso, gram_we and osc_en are low and the index is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing each transfer |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low when unused |
| osc_en | output | 1 | Oscillator start flag |
| gram_we | output | 1 | One-cycle pixel word strobe |
| gram_wdata | output | 16 | Pixel word accompanying gram_we |

## Verification
Each serial pin passes through SYNC_STAGES flops and one edge-detect register. A completed byte is therefore registered two cycles after the synchronized rising edge. Any write strobe or gram_we follows one cycle later, about five system clocks after the pin edge. spi_miso updates about four clocks after a falling serial edge. The bench holds each serial clock phase for eight system clocks and samples spi_miso just before it raises the clock. It compares read words and pixel strobes only at frame boundaries or on the cycle gram_we is high, so both are checked only after they have settled.

// File: rtl/lcdc_spi_pkg.sv
package lcdc_spi_pkg;
  localparam logic [4:0]  HDR_PATTERN    = 5'b01110;
  localparam logic [15:0] PIXEL_PORT_IDX = 16'h0022;
  localparam logic [15:0] ID_CODE_IDX    = 16'h0000;
  localparam logic [11:0] ID_CODE_FAMILY = 12'h922;
  localparam logic [15:0] OSC_START_VAL  = 16'h0001;

  typedef enum logic [1:0] {
    FR_HDR = 2'd0,
    FR_ACT = 2'd1,
    FR_IGN = 2'd2
  } frame_st_e;

  typedef struct packed {
    logic sel_data;
    logic is_read;
  } hdr_t;
endpackage

// File: rtl/lcdc_spi_shift.sv
module lcdc_spi_shift #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  input  logic [7:0]       tx_byte_i,
  output logic             miso_o,
  output logic             sel_o,
  output logic             byte_vld_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic [7:0]       rx_byte_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
  logic sclk_prev;
  logic sclk_s, cs_s, mosi_s, rise, fall;

  logic [2:0]       bit_cnt_q, bit_cnt_d;
  logic [CNT_W-1:0] byte_cnt_q, byte_cnt_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [6:0]       rx_sr_q, rx_sr_d;
  logic [7:0]       rx_byte_q, rx_byte_d;
  logic [7:0]       tx_sr_q, tx_sr_d;
  logic             miso_q, miso_d;
  logic             vld_q, vld_d;

  assign sclk_s = sclk_sy[SYNC_STAGES-1];
  assign cs_s   = cs_sy[SYNC_STAGES-1];
  assign mosi_s = mosi_sy[SYNC_STAGES-1];
  assign rise   = sclk_s & ~sclk_prev & ~cs_s;
  assign fall   = ~sclk_s & sclk_prev & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy   <= '0;
      cs_sy     <= '1;
      mosi_sy   <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_sy   <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      cs_sy     <= {cs_sy[SYNC_STAGES-2:0], cs_n_i};
      mosi_sy   <= {mosi_sy[SYNC_STAGES-2:0], mosi_i};
      sclk_prev <= sclk_s;
    end
  end

  always_comb begin
    bit_cnt_d  = bit_cnt_q;
    byte_cnt_d = byte_cnt_q;
    idx_d      = idx_q;
    rx_sr_d    = rx_sr_q;
    rx_byte_d  = rx_byte_q;
    tx_sr_d    = tx_sr_q;
    miso_d     = miso_q;
    vld_d      = 1'b0;
    if (cs_s) begin
      bit_cnt_d  = '0;
      byte_cnt_d = '0;
      tx_sr_d    = '0;
      miso_d     = 1'b0;
    end else begin
      if (rise) begin
        rx_sr_d   = {rx_sr_q[5:0], mosi_s};
        bit_cnt_d = bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          vld_d     = 1'b1;
          rx_byte_d = {rx_sr_q, mosi_s};
          idx_d     = byte_cnt_q;
          if (byte_cnt_q != CNT_MAX) byte_cnt_d = byte_cnt_q + 1'b1;
        end
      end
      if (fall) begin
        if (bit_cnt_q == 3'd0) begin
          miso_d  = tx_byte_i[7];
          tx_sr_d = {tx_byte_i[6:0], 1'b0};
        end else begin
          miso_d  = tx_sr_q[7];
          tx_sr_d = {tx_sr_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      idx_q      <= '0;
      rx_sr_q    <= '0;
      rx_byte_q  <= '0;
      tx_sr_q    <= '0;
      miso_q     <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      bit_cnt_q  <= bit_cnt_d;
      byte_cnt_q <= byte_cnt_d;
      idx_q      <= idx_d;
      rx_sr_q    <= rx_sr_d;
      rx_byte_q  <= rx_byte_d;
      tx_sr_q    <= tx_sr_d;
      miso_q     <= miso_d;
      vld_q      <= vld_d;
    end
  end

  assign miso_o     = miso_q;
  assign sel_o      = ~cs_s;
  assign byte_vld_o = vld_q;
  assign byte_idx_o = idx_q;
  assign byte_cnt_o = byte_cnt_q;
  assign rx_byte_o  = rx_byte_q;

  // R9
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt_q == 3'd0 && byte_cnt_q == '0 && !miso_q));

  // R4
  byte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (bit_cnt_q == 3'd0));
endmodule

// File: rtl/lcdc_frame_ctl.sv
module lcdc_frame_ctl
  import lcdc_spi_pkg::*;
#(
  parameter logic DEV_ID = 1'b1,
  parameter int   CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             byte_vld_i,
  input  logic [CNT_W-1:0] byte_idx_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic [7:0]       rx_byte_i,
  input  logic [15:0]      reg_rdata_i,
  input  logic             osc_en_i,
  output logic [7:0]       tx_byte_o,
  output logic [15:0]      index_o,
  output logic             wr_en_o,
  output logic [15:0]      wr_data_o,
  output logic             gram_we_o,
  output logic [15:0]      gram_data_o,
  output logic             ignore_o
);
  frame_st_e   st_q, st_d;
  hdr_t        hdr_q, hdr_d;
  logic [7:0]  hi_q, hi_d;
  logic [15:0] index_q, index_d;
  logic [15:0] rd_word_q, rd_word_d;
  logic        wr_en_q, wr_en_d;
  logic [15:0] wr_data_q, wr_data_d;
  logic        gram_we_q, gram_we_d;
  logic [15:0] gram_data_q, gram_data_d;
  logic [15:0] status_w;

  assign status_w = {osc_en_i, 7'b0, index_q[7:0]};

  always_comb begin
    st_d        = st_q;
    hdr_d       = hdr_q;
    hi_d        = hi_q;
    index_d     = index_q;
    rd_word_d   = rd_word_q;
    wr_en_d     = 1'b0;
    wr_data_d   = wr_data_q;
    gram_we_d   = 1'b0;
    gram_data_d = gram_data_q;
    if (!sel_i) begin
      st_d = FR_HDR;
    end else if (byte_vld_i) begin
      unique case (st_q)
        FR_HDR: begin
          if (rx_byte_i[7:3] == HDR_PATTERN && rx_byte_i[2] == DEV_ID) begin
            st_d           = FR_ACT;
            hdr_d.sel_data = rx_byte_i[1];
            hdr_d.is_read  = rx_byte_i[0];
            rd_word_d      = rx_byte_i[1] ? reg_rdata_i : status_w;
          end else begin
            st_d = FR_IGN;
          end
        end
        FR_ACT: begin
          if (!hdr_q.is_read) begin
            if (byte_idx_i[0]) begin
              hi_d = rx_byte_i;
            end else if (hdr_q.sel_data) begin
              if (index_q == PIXEL_PORT_IDX) begin
                gram_we_d   = 1'b1;
                gram_data_d = {hi_q, rx_byte_i};
              end else begin
                wr_en_d   = 1'b1;
                wr_data_d = {hi_q, rx_byte_i};
              end
            end else if (byte_idx_i == CNT_W'(2)) begin
              index_d = {hi_q, rx_byte_i};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= FR_HDR;
      hdr_q       <= '0;
      hi_q        <= '0;
      index_q     <= '0;
      rd_word_q   <= '0;
      wr_en_q     <= 1'b0;
      wr_data_q   <= '0;
      gram_we_q   <= 1'b0;
      gram_data_q <= '0;
    end else begin
      st_q        <= st_d;
      hdr_q       <= hdr_d;
      hi_q        <= hi_d;
      index_q     <= index_d;
      rd_word_q   <= rd_word_d;
      wr_en_q     <= wr_en_d;
      wr_data_q   <= wr_data_d;
      gram_we_q   <= gram_we_d;
      gram_data_q <= gram_data_d;
    end
  end

  always_comb begin
    tx_byte_o = 8'h00;
    if (st_q == FR_ACT && hdr_q.is_read) begin
      if (byte_cnt_i == CNT_W'(2))      tx_byte_o = rd_word_q[15:8];
      else if (byte_cnt_i == CNT_W'(3)) tx_byte_o = rd_word_q[7:0];
    end
  end

  assign index_o     = index_q;
  assign wr_en_o     = wr_en_q;
  assign wr_data_o   = wr_data_q;
  assign gram_we_o   = gram_we_q;
  assign gram_data_o = gram_data_q;
  assign ignore_o    = (st_q == FR_IGN);

  // R6
  gram_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gram_we_q |=> !gram_we_q);

  // R1
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_IGN) |-> (!wr_en_q && !gram_we_q));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FR_ACT) |=> $stable(index_q));
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
  import lcdc_spi_pkg::*;
#(
  parameter int         NUM_REGS = 32,
  parameter int         REG_BASE = 1,
  parameter logic [3:0] DEV_REV  = 4'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rdata_o,
  output logic        osc_en_o
);
  logic [15:0]         regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;
  logic                osc_q, osc_d;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    assign hit[g] = (addr_i == 16'(REG_BASE + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 regs_q[g] <= '0;
      else if (wr_en_i && hit[g]) regs_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    osc_d = osc_q;
    if (wr_en_i && addr_i == ID_CODE_IDX && wr_data_i == OSC_START_VAL) osc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_q <= 1'b0;
    else        osc_q <= osc_d;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ID_CODE_IDX) rdata_o = {ID_CODE_FAMILY, DEV_REV};
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) rdata_o = regs_q[i];
    end
  end

  assign osc_en_o = osc_q;

  // R7
  we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit & {NUM_REGS{wr_en_i}}));

  // R5
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_q |=> osc_q);
endmodule

// File: rtl/lcdc_spi_front.sv
module lcdc_spi_front #(
  parameter int         SYNC_STAGES = 2,
  parameter int         CNT_W       = 8,
  parameter logic       DEV_ID      = 1'b1,
  parameter logic [3:0] DEV_REV     = 4'h1,
  parameter int         NUM_REGS    = 32,
  parameter int         REG_BASE    = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        osc_en,
  output logic        gram_we,
  output logic [15:0] gram_wdata
);
  logic             sel, byte_vld, wr_en, ignore;
  logic [CNT_W-1:0] byte_idx, byte_cnt;
  logic [7:0]       rx_byte, tx_byte;
  logic [15:0]      index, wr_data, reg_rdata;

  lcdc_spi_shift #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .tx_byte_i(tx_byte), .miso_o(spi_miso), .sel_o(sel), .byte_vld_o(byte_vld),
    .byte_idx_o(byte_idx), .byte_cnt_o(byte_cnt), .rx_byte_o(rx_byte)
  );

  lcdc_frame_ctl #(.DEV_ID(DEV_ID), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .byte_vld_i(byte_vld), .byte_idx_i(byte_idx),
    .byte_cnt_i(byte_cnt), .rx_byte_i(rx_byte), .reg_rdata_i(reg_rdata), .osc_en_i(osc_en),
    .tx_byte_o(tx_byte), .index_o(index), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .gram_we_o(gram_we), .gram_data_o(gram_wdata), .ignore_o(ignore)
  );

  lcdc_regfile #(.NUM_REGS(NUM_REGS), .REG_BASE(REG_BASE), .DEV_REV(DEV_REV)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(index), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rdata_o(reg_rdata), .osc_en_o(osc_en)
  );

  // R1
  ign_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignore |-> !spi_miso);
endmodule

// File: tb/sim_lcdc_spi_front.sv
module sim_lcdc_spi_front;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, osc_en, gram_we;
  logic [15:0] gram_wdata;

  always #2.5 clk = ~clk;

  lcdc_spi_front u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .osc_en(osc_en), .gram_we(gram_we), .gram_wdata(gram_wdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];
  logic [15:0] gram_exp_q [$];
  string       gram_tag_q [$];
  logic [15:0] rd_exp_q [$];
  logic [15:0] rd_obs_q [$];
  string       rd_tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr(input bit id, input bit rs, input bit rw);
    return {5'b01110, id, rs, rw};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nbytes, input int extra_bits);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int b = 0; b <= nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (b == nbytes && (7 - i) >= extra_bits) break;
        mosi = txb[b][i];
        wait_clk(HALF);
        rxb[b][i] = miso;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
      end
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic wr_idx(input logic [15:0] idx);
    txb[0] = hdr(1, 0, 0); txb[1] = idx[15:8]; txb[2] = idx[7:0];
    frame(3, 0);
  endtask

  task automatic wr_word(input logic [15:0] v);
    txb[0] = hdr(1, 1, 0); txb[1] = v[15:8]; txb[2] = v[7:0];
    frame(3, 0);
  endtask

  task automatic rd_generic(input bit rs, input logic [15:0] exp, input string tag);
    txb[0] = hdr(1, rs, 1);
    for (int k = 1; k < 5; k++) txb[k] = 8'h00;
    frame(5, 0);
    chk(rxb[1] == 8'h00, {tag, " dummy byte"}, {8'h00, rxb[1]}, 16'h0000);
    chk(rxb[4] == 8'h00, {tag, " trailing byte"}, {8'h00, rxb[4]}, 16'h0000);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    rd_obs_q.push_back({rxb[2], rxb[3]});
  endtask

  task automatic rd_at(input logic [15:0] idx, input logic [15:0] exp, input string tag);
    wr_idx(idx);
    rd_generic(1'b1, exp, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (gram_we) begin
        if (gram_exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected pixel strobe", gram_wdata, 16'h0000);
        end else begin
          chk(gram_wdata == gram_exp_q[0], gram_tag_q[0], gram_wdata, gram_exp_q[0]);
          void'(gram_exp_q.pop_front());
          void'(gram_tag_q.pop_front());
        end
      end
      while (rd_obs_q.size() > 0 && rd_exp_q.size() > 0) begin
        chk(rd_obs_q[0] == rd_exp_q[0], rd_tag_q[0], rd_obs_q[0], rd_exp_q[0]);
        void'(rd_obs_q.pop_front());
        void'(rd_exp_q.pop_front());
        void'(rd_tag_q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_clk(10);
    // R10 reset state
    chk(miso == 1'b0, "R10 miso at reset", {15'b0, miso}, 16'h0000);
    chk(gram_we == 1'b0, "R10 gram_we at reset", {15'b0, gram_we}, 16'h0000);
    chk(osc_en == 1'b0, "R10 osc_en at reset", {15'b0, osc_en}, 16'h0000);
    rst_n = 1'b1;
    wait_clk(4);
    rd_generic(1'b1, 16'h9221, "R10 index zero after reset reads device code");

    // R5 device code
    rd_at(16'h0000, 16'h9221, "R5 device code");

    // R3 / R7 writes and readback
    rd_at(16'h0002, 16'h0000, "R7 reset value of word 2");
    wr_idx(16'h0003); wr_word(16'h1030);
    wr_idx(16'h0001); wr_word(16'hA5C3);
    wr_idx(16'h0020); wr_word(16'hFFFF);
    rd_at(16'h0003, 16'h1030, "R3 word 3 readback");
    rd_at(16'h0001, 16'hA5C3, "R3 word 1 readback");
    rd_at(16'h0020, 16'hFFFF, "R7 last implemented word");

    // R3 several pairs in one frame: last pair wins
    wr_idx(16'h0005);
    txb[0] = hdr(1, 1, 0); txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33; txb[4] = 8'h44;
    frame(5, 0);
    rd_at(16'h0005, 16'h3344, "R3 repeated pair");

    // R3 truncated pair writes nothing
    wr_idx(16'h0005);
    txb[0] = hdr(1, 1, 0); txb[1] = 8'h55;
    frame(2, 0);
    rd_at(16'h0005, 16'h3344, "R3 truncated pair ignored");

    // R7 unimplemented indices
    wr_idx(16'h0030); wr_word(16'hBEEF);
    rd_at(16'h0030, 16'h0000, "R7 unimplemented index");
    rd_at(16'h0103, 16'h0000, "R2 R7 upper index byte selects nothing");
    rd_at(16'h0003, 16'h1030, "R2 word 3 untouched");

    // R5 oscillator start
    wr_idx(16'h0000); wr_word(16'h0002);
    chk(osc_en == 1'b0, "R5 other value leaves osc", {15'b0, osc_en}, 16'h0000);
    wr_word(16'h0001);
    chk(osc_en == 1'b1, "R5 osc started", {15'b0, osc_en}, 16'h0001);
    rd_at(16'h0000, 16'h9221, "R5 code unchanged after write");

    // R8 status
    wr_idx(16'h005A);
    rd_generic(1'b0, 16'h805A, "R8 status word");

    // R6 pixel port
    wr_idx(16'h0022);
    txb[0] = hdr(1, 1, 0);
    txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'hAB; txb[4] = 8'hCD; txb[5] = 8'h00; txb[6] = 8'h07;
    gram_exp_q.push_back(16'h1234); gram_tag_q.push_back("R6 pixel word 1");
    gram_exp_q.push_back(16'hABCD); gram_tag_q.push_back("R6 pixel word 2");
    gram_exp_q.push_back(16'h0007); gram_tag_q.push_back("R6 pixel word 3");
    frame(7, 0);
    rd_generic(1'b1, 16'h0000, "R6 pixel port reads zero");
    chk(gram_exp_q.size() == 0, "R6 all pixel strobes seen", 16'(gram_exp_q.size()), 16'h0000);

    // R1 wrong identity and wrong signature
    wr_idx(16'h0003);
    txb[0] = hdr(0, 1, 0); txb[1] = 8'hDE; txb[2] = 8'hAD;
    frame(3, 0);
    txb[0] = 8'b0111_1110; txb[1] = 8'hDE; txb[2] = 8'hAD;
    frame(3, 0);
    txb[0] = hdr(0, 0, 0); txb[1] = 8'h00; txb[2] = 8'h07;
    frame(3, 0);
    rd_generic(1'b1, 16'h1030, "R1 foreign frames left word 3");
    wr_idx(16'h0003);
    txb[0] = hdr(0, 1, 1); txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    frame(4, 0);
    chk({rxb[2], rxb[3]} == 16'h0000 && rxb[1] == 8'h00, "R1 miso low on foreign read",
        {rxb[2], rxb[3]}, 16'h0000);

    // R9 partial byte then clean frame
    txb[0] = 8'hFF;
    frame(0, 5);
    chk(miso == 1'b0, "R9 miso low when deselected", {15'b0, miso}, 16'h0000);
    rd_generic(1'b1, 16'h1030, "R9 frame after partial byte");

    wait_clk(20);
    chk(rd_exp_q.size() == 0, "R4 all reads compared", 16'(rd_exp_q.size()), 16'h0000);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule